// File: doc/BRIEF.md
# Calibration Pulse Board Controller

This block is the digital control logic of a 128-channel calibration pulse board. It runs on the board's 40 MHz system clock. An I2C slave gives access to a small register bank. The bank holds one enable bit per pulser channel, a 16-bit amplitude code for the shared DAC, one delay code for each group of 16 channels, a few regulator control bits and a read-only temperature reading supplied from outside.

When an already-decoded calibration command strobe arrives, the block sends a pulse one clock wide to every channel whose enable bit is set. Disabled channels stay low. The delay codes are presented continuously to external delay elements. Register writes are never applied in a cycle in which a strobe is being sampled, so the outputs do not change under a firing command.

Top module: `calpulse_ctrl`

## Requirements
- R1: While reset is asserted, and right after it is released, all channel outputs, the DAC code, every bulk delay code, the regulator bits and the data line drive are 0.
- R2: The I2C slave answers only its 7-bit address 0x2C, by pulling the data line low in the acknowledge slot. A transfer to any other address gets no acknowledge and changes no register.
- R3: After the address byte with R/W=0, the first byte sets the register index. Each following data byte is written at the current index, and the index then advances by one. A read (address byte with R/W=1, after a repeated start) returns bytes MSB first, starting at the current index and advancing by one after each byte the master acknowledges.
- R4: Indices 0x00–0x0F hold the channel enables. Index 4k+j holds bits [31-8j:24-8j] of enable word k, and bit n of word k enables channel 32k+n. For example, index 0x07 bit 5 is channel 37.
- R5: Index 0x10 holds DAC code bits [15:8] and index 0x11 holds bits [7:0].
- R6: Index 0x12+b holds the delay code of bulk b (channels 16b..16b+15), driven on bulk_delay[5b+4:5b]. A written value above 24 is stored as 24, so no output code ever exceeds 24.
- R7: Index 0x1A bits [3:0] drive the regulator controls, and bits [7:4] read back as 0. Index 0x1B reads the temp_code input. Writes to 0x1B have no effect.
- R8: If cmd_strobe is high at a clock edge, chan_fire equals the enable vector for the cycle after that edge. Otherwise chan_fire is all zero. A single-cycle strobe therefore gives each enabled channel exactly one pulse one cycle wide.
- R9: A register write that completes while cmd_strobe is high is held, and it takes effect in the first cycle in which the strobe is low. Enables, DAC code, delay codes and regulator bits never change on the edge that follows a cycle with the strobe high.
- R10: Reading any writable register returns the last value written to it, after the clamp of R6. Indices 0x1C–0xFF read as 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 40 MHz system clock |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_i | input | 1 | I2C clock line |
| sda_i | input | 1 | I2C data line as seen on the bus |
| sda_oe | output | 1 | When 1, the data line is pulled low |
| cmd_strobe | input | 1 | Decoded calibration command, one clock per command |
| temp_code | input | 8 | Temperature reading returned at index 0x1B |
| chan_fire | output | 128 | Per-channel command pulses |
| dac_code | output | 16 | Amplitude code for the shared DAC |
| bulk_delay | output | 40 | Eight 5-bit delay codes, bulk b at [5b+4:5b] |
| reg_ctl | output | 4 | Regulator control bits |

## Verification
Command gating is tried with an all-zero enable set, a single enable bit, a dense mixed pattern and back-to-back strobes. Together these separate a wrong word/byte mapping, a stretched or missing pulse, and leakage onto disabled channels. The delay path gets codes below, at and above the limit of 24, which tells clamping apart from truncation. Wrong-address, read-only and unmapped-index writes are each followed by a readback that shows nothing was touched. A write landing inside a held strobe shows whether it is deferred or lost.

// File: rtl/cp_pkg.sv
package cp_pkg;

    typedef enum logic [2:0] {
        I_IDLE,
        I_RX,
        I_RXACK,
        I_TX,
        I_TXACK
    } i2c_st_e;

    typedef enum logic [1:0] {
        B_ADDR,
        B_IDX,
        B_DATA
    } byte_role_e;

    typedef struct packed {
        logic [1:0] scl_m;
        logic [1:0] sda_m;
        logic       scl_p;
        logic       sda_p;
        i2c_st_e    st;
        byte_role_e role;
        logic [7:0] sh;
        logic [3:0] cnt;
        logic       rw;
        logic       oe;
        logic [7:0] idx;
        logic       wr_v;
        logic [7:0] wr_a;
        logic [7:0] wr_d;
    } i2c_state_t;

endpackage

// File: rtl/cp_i2c_slave.sv
module cp_i2c_slave
    import cp_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h2C
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_oe,
    output logic       wr_v,
    output logic [7:0] wr_a,
    output logic [7:0] wr_d,
    output logic [7:0] rd_a,
    input  logic [7:0] rd_d
);

    i2c_state_t q, d;
    logic scl, sda, rise, fall, start_ev, stop_ev;

    always_comb begin
        d       = q;
        d.wr_v  = 1'b0;
        d.scl_m = {q.scl_m[0], scl_i};
        d.sda_m = {q.sda_m[0], sda_i};
        d.scl_p = q.scl_m[1];
        d.sda_p = q.sda_m[1];

        scl      = q.scl_m[1];
        sda      = q.sda_m[1];
        rise     = scl & ~q.scl_p;
        fall     = ~scl & q.scl_p;
        start_ev = scl & q.scl_p & ~sda & q.sda_p;
        stop_ev  = scl & q.scl_p & sda & ~q.sda_p;

        if (stop_ev) begin
            d.st = I_IDLE;
            d.oe = 1'b0;
        end else if (start_ev) begin
            d.st   = I_RX;
            d.role = B_ADDR;
            d.cnt  = 4'd0;
            d.oe   = 1'b0;
        end else begin
            case (q.st)
                I_RX: begin
                    if (rise) begin
                        d.sh  = {q.sh[6:0], sda};
                        d.cnt = q.cnt + 4'd1;
                    end else if (fall && q.cnt == 4'd8) begin
                        d.cnt = 4'd0;
                        d.st  = I_RXACK;
                        d.oe  = 1'b1;
                        case (q.role)
                            B_ADDR: begin
                                if (q.sh[7:1] == DEV_ADDR) begin
                                    d.rw = q.sh[0];
                                end else begin
                                    d.st = I_IDLE;
                                    d.oe = 1'b0;
                                end
                            end
                            B_IDX: d.idx = q.sh;
                            default: begin
                                d.wr_v = 1'b1;
                                d.wr_a = q.idx;
                                d.wr_d = q.sh;
                                d.idx  = q.idx + 8'd1;
                            end
                        endcase
                    end
                end
                I_RXACK: begin
                    if (fall) begin
                        d.oe = 1'b0;
                        if (q.role == B_ADDR && q.rw) begin
                            d.st  = I_TX;
                            d.sh  = rd_d;
                            d.oe  = ~rd_d[7];
                            d.cnt = 4'd0;
                        end else begin
                            d.st   = I_RX;
                            d.role = (q.role == B_ADDR) ? B_IDX : B_DATA;
                        end
                    end
                end
                I_TX: begin
                    if (rise) begin
                        d.cnt = q.cnt + 4'd1;
                    end else if (fall) begin
                        if (q.cnt == 4'd8) begin
                            d.oe = 1'b0;
                            d.st = I_TXACK;
                        end else begin
                            d.sh = {q.sh[6:0], 1'b1};
                            d.oe = ~q.sh[6];
                        end
                    end
                end
                I_TXACK: begin
                    if (rise && sda) begin
                        d.st = I_IDLE;
                    end else if (fall) begin
                        d.idx = q.idx + 8'd1;
                        d.sh  = rd_d;
                        d.oe  = ~rd_d[7];
                        d.cnt = 4'd0;
                        d.st  = I_TX;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q       <= '0;
            q.scl_m <= 2'b11;
            q.sda_m <= 2'b11;
            q.scl_p <= 1'b1;
            q.sda_p <= 1'b1;
            q.st    <= I_IDLE;
            q.role  <= B_ADDR;
        end else begin
            q <= d;
        end
    end

    assign sda_oe = q.oe;
    assign wr_v   = q.wr_v;
    assign wr_a   = q.wr_a;
    assign wr_d   = q.wr_d;
    assign rd_a   = (q.st == I_TXACK) ? q.idx + 8'd1 : q.idx;

endmodule

// File: rtl/cp_regbank.sv
module cp_regbank #(
    parameter int N_CH    = 128,
    parameter int WORD_W  = 32,
    parameter int BULK    = 16,
    parameter int DAC_W   = 16,
    parameter int DLY_MAX = 24,
    parameter int CTL_W   = 4,
    parameter int TEMP_W  = 8,
    localparam int N_BULK    = N_CH / BULK,
    localparam int DLY_W     = $clog2(DLY_MAX + 1)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cmd_strobe,
    input  logic                      wr_v,
    input  logic [7:0]                wr_a,
    input  logic [7:0]                wr_d,
    input  logic [7:0]                rd_a,
    output logic [7:0]                rd_d,
    input  logic [TEMP_W-1:0]         temp_code,
    output logic [N_CH-1:0]           en_all,
    output logic [DAC_W-1:0]          dac_code,
    output logic [N_BULK*DLY_W-1:0]   bulk_delay,
    output logic [CTL_W-1:0]          reg_ctl
);

    localparam int BPW       = WORD_W / 8;
    localparam int EN_BYTES  = N_CH / 8;
    localparam int DAC_BYTES = DAC_W / 8;
    localparam int A_EN      = 0;
    localparam int A_DAC     = A_EN + EN_BYTES;
    localparam int A_DLY     = A_DAC + DAC_BYTES;
    localparam int A_CTL     = A_DLY + N_BULK;
    localparam int A_TEMP    = A_CTL + 1;

    typedef struct packed {
        logic [N_CH-1:0]         en;
        logic [DAC_W-1:0]        dac;
        logic [N_BULK*DLY_W-1:0] dly;
        logic [CTL_W-1:0]        ctl;
        logic                    pv;
        logic [7:0]              pa;
        logic [7:0]              pd;
    } rb_t;

    rb_t q, d;

    always_comb begin
        d = q;
        if (wr_v) begin
            d.pv = 1'b1;
            d.pa = wr_a;
            d.pd = wr_d;
        end
        if (q.pv && !cmd_strobe) begin
            if (!wr_v) d.pv = 1'b0;
            for (int b = 0; b < EN_BYTES; b++) begin
                if (q.pa == 8'(A_EN + b))
                    d.en[(b / BPW) * WORD_W + (BPW - 1 - (b % BPW)) * 8 +: 8] = q.pd;
            end
            for (int b = 0; b < DAC_BYTES; b++) begin
                if (q.pa == 8'(A_DAC + b))
                    d.dac[(DAC_BYTES - 1 - b) * 8 +: 8] = q.pd;
            end
            for (int i = 0; i < N_BULK; i++) begin
                if (q.pa == 8'(A_DLY + i))
                    d.dly[i * DLY_W +: DLY_W] = (q.pd > 8'(DLY_MAX)) ?
                        DLY_W'(DLY_MAX) : q.pd[DLY_W-1:0];
            end
            if (q.pa == 8'(A_CTL)) d.ctl = q.pd[CTL_W-1:0];
        end
    end

    always_comb begin
        rd_d = '0;
        for (int b = 0; b < EN_BYTES; b++) begin
            if (rd_a == 8'(A_EN + b))
                rd_d = q.en[(b / BPW) * WORD_W + (BPW - 1 - (b % BPW)) * 8 +: 8];
        end
        for (int b = 0; b < DAC_BYTES; b++) begin
            if (rd_a == 8'(A_DAC + b))
                rd_d = q.dac[(DAC_BYTES - 1 - b) * 8 +: 8];
        end
        for (int i = 0; i < N_BULK; i++) begin
            if (rd_a == 8'(A_DLY + i))
                rd_d = 8'(q.dly[i * DLY_W +: DLY_W]);
        end
        if (rd_a == 8'(A_CTL))  rd_d = 8'(q.ctl);
        if (rd_a == 8'(A_TEMP)) rd_d = 8'(temp_code);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign en_all     = q.en;
    assign dac_code   = q.dac;
    assign bulk_delay = q.dly;
    assign reg_ctl    = q.ctl;

endmodule

// File: rtl/cp_fire.sv
module cp_fire #(
    parameter int N_CH = 128
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cmd_strobe,
    input  logic [N_CH-1:0] en_all,
    output logic [N_CH-1:0] chan_fire
);

    logic [N_CH-1:0] fire_d, fire_q;

    always_comb begin
        fire_d = cmd_strobe ? en_all : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) fire_q <= '0;
        else        fire_q <= fire_d;
    end

    assign chan_fire = fire_q;

endmodule

// File: rtl/calpulse_ctrl.sv
module calpulse_ctrl #(
    parameter int         N_CH     = 128,
    parameter int         WORD_W   = 32,
    parameter int         BULK     = 16,
    parameter int         DAC_W    = 16,
    parameter int         DLY_MAX  = 24,
    parameter int         CTL_W    = 4,
    parameter int         TEMP_W   = 8,
    parameter logic [6:0] DEV_ADDR = 7'h2C,
    localparam int N_BULK = N_CH / BULK,
    localparam int DLY_W  = $clog2(DLY_MAX + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    scl_i,
    input  logic                    sda_i,
    output logic                    sda_oe,
    input  logic                    cmd_strobe,
    input  logic [TEMP_W-1:0]       temp_code,
    output logic [N_CH-1:0]         chan_fire,
    output logic [DAC_W-1:0]        dac_code,
    output logic [N_BULK*DLY_W-1:0] bulk_delay,
    output logic [CTL_W-1:0]        reg_ctl
);

    logic            wr_v;
    logic [7:0]      wr_a, wr_d, rd_a, rd_d;
    logic [N_CH-1:0] en_all;

    cp_i2c_slave #(.DEV_ADDR(DEV_ADDR)) u_i2c (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i), .sda_oe(sda_oe),
        .wr_v(wr_v), .wr_a(wr_a), .wr_d(wr_d), .rd_a(rd_a), .rd_d(rd_d)
    );

    cp_regbank #(
        .N_CH(N_CH), .WORD_W(WORD_W), .BULK(BULK), .DAC_W(DAC_W),
        .DLY_MAX(DLY_MAX), .CTL_W(CTL_W), .TEMP_W(TEMP_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .cmd_strobe(cmd_strobe),
        .wr_v(wr_v), .wr_a(wr_a), .wr_d(wr_d), .rd_a(rd_a), .rd_d(rd_d),
        .temp_code(temp_code), .en_all(en_all), .dac_code(dac_code),
        .bulk_delay(bulk_delay), .reg_ctl(reg_ctl)
    );

    cp_fire #(.N_CH(N_CH)) u_fire (
        .clk(clk), .rst_n(rst_n), .cmd_strobe(cmd_strobe),
        .en_all(en_all), .chan_fire(chan_fire)
    );

endmodule

// File: rtl/cp_chk.sv
module cp_chk #(
    parameter int N_CH    = 128,
    parameter int BULK    = 16,
    parameter int DAC_W   = 16,
    parameter int DLY_MAX = 24,
    parameter int CTL_W   = 4,
    localparam int N_BULK = N_CH / BULK,
    localparam int DLY_W  = $clog2(DLY_MAX + 1)
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    cmd_strobe,
    input logic                    sda_oe,
    input logic [N_CH-1:0]         en_all,
    input logic [N_CH-1:0]         chan_fire,
    input logic [DAC_W-1:0]        dac_code,
    input logic [N_BULK*DLY_W-1:0] bulk_delay,
    input logic [CTL_W-1:0]        reg_ctl
);

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (chan_fire == '0 && dac_code == '0 && bulk_delay == '0 &&
                    reg_ctl == '0 && !sda_oe));

    // R8
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_strobe |=> chan_fire == '0);

    // R8
    fire_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_strobe |=> chan_fire == $past(en_all));

    // R9
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_strobe |=> ($stable(en_all) && $stable(dac_code) &&
                        $stable(bulk_delay) && $stable(reg_ctl)));

    for (genvar g = 0; g < N_BULK; g++) begin : g_dly
        // R6
        dly_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
            bulk_delay[g*DLY_W +: DLY_W] <= DLY_W'(DLY_MAX));
    end

endmodule

bind calpulse_ctrl cp_chk #(
    .N_CH(N_CH), .BULK(BULK), .DAC_W(DAC_W), .DLY_MAX(DLY_MAX), .CTL_W(CTL_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .cmd_strobe(cmd_strobe), .sda_oe(sda_oe),
    .en_all(en_all), .chan_fire(chan_fire), .dac_code(dac_code),
    .bulk_delay(bulk_delay), .reg_ctl(reg_ctl)
);

// File: tb/tb_calpulse_ctrl.sv
module tb_calpulse_ctrl;

    localparam int H = 8;
    localparam logic [6:0] DEV = 7'h2C;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         scl_m = 1'b1;
    logic         sda_m = 1'b1;
    logic         sda_oe;
    logic         cmd_strobe = 1'b0;
    logic [7:0]   temp_code = 8'h5A;
    logic [127:0] chan_fire;
    logic [15:0]  dac_code;
    logic [39:0]  bulk_delay;
    logic [3:0]   reg_ctl;
    logic         sda_line;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    logic [7:0]   wbuf [0:31];
    logic [7:0]   rbuf [0:31];
    logic [127:0] exp_en;

    assign sda_line = sda_m & ~sda_oe;

    always #4 clk = ~clk;

    calpulse_ctrl dut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
        .cmd_strobe(cmd_strobe), .temp_code(temp_code), .chan_fire(chan_fire),
        .dac_code(dac_code), .bulk_delay(bulk_delay), .reg_ctl(reg_ctl)
    );

    task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic hp();
        repeat (H) @(negedge clk);
    endtask

    task automatic i2c_start();
        sda_m = 1'b1; hp();
        scl_m = 1'b1; hp();
        sda_m = 1'b0; hp();
        scl_m = 1'b0; hp();
    endtask

    task automatic i2c_stop();
        sda_m = 1'b0; hp();
        scl_m = 1'b1; hp();
        sda_m = 1'b1; hp();
    endtask

    task automatic i2c_wbyte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; hp();
            scl_m = 1'b1; hp();
            scl_m = 1'b0;
        end
        sda_m = 1'b1; hp();
        scl_m = 1'b1; hp();
        ack = ~sda_line;
        scl_m = 1'b0;
    endtask

    task automatic i2c_rbyte(input logic last, output logic [7:0] v);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            hp();
            scl_m = 1'b1; hp();
            v[i] = sda_line;
            scl_m = 1'b0;
        end
        sda_m = last; hp();
        scl_m = 1'b1; hp();
        scl_m = 1'b0; hp();
        sda_m = 1'b1;
    endtask

    task automatic wr_regs(input logic [6:0] dev, input logic [7:0] idx, input int n,
                           output logic aok);
        logic a;
        i2c_start();
        i2c_wbyte({dev, 1'b0}, aok);
        if (aok) begin
            i2c_wbyte(idx, a);
            for (int i = 0; i < n; i++) i2c_wbyte(wbuf[i], a);
        end
        i2c_stop();
        hp();
    endtask

    task automatic rd_regs(input logic [7:0] idx, input int n);
        logic a;
        i2c_start();
        i2c_wbyte({DEV, 1'b0}, a);
        i2c_wbyte(idx, a);
        i2c_start();
        i2c_wbyte({DEV, 1'b1}, a);
        for (int i = 0; i < n; i++) i2c_rbyte(i == n - 1, rbuf[i]);
        i2c_stop();
        hp();
    endtask

    task automatic pulse_and_check(input string req, input logic [127:0] exp);
        @(negedge clk); cmd_strobe = 1'b1;
        @(negedge clk); cmd_strobe = 1'b0;
        chk(req, chan_fire, exp);
        @(negedge clk);
        chk(req, chan_fire, '0);
    endtask

    task automatic model_en();
        for (int k = 0; k < 4; k++)
            for (int j = 0; j < 4; j++)
                exp_en[32*k + 8*(3-j) +: 8] = wbuf[4*k + j];
    endtask

    task automatic t_reset();
        chk("R1 fire", chan_fire, '0);
        chk("R1 dac", 128'(dac_code), '0);
        chk("R1 delay", 128'(bulk_delay), '0);
        chk("R1 ctl", 128'(reg_ctl), '0);
        chk("R1 sda", 128'(sda_oe), '0);
        repeat (3) @(negedge clk);
        chk("R8 no strobe no pulse", chan_fire, '0);
    endtask

    task automatic t_single_channel();
        logic a;
        for (int i = 0; i < 16; i++) wbuf[i] = 8'h00;
        wbuf[7] = 8'h20;
        wr_regs(DEV, 8'h00, 16, a);
        chk("R2 ack own address", 128'(a), 128'(1));
        pulse_and_check("R4 R8 channel 37 only", 128'(1) << 37);
    endtask

    task automatic t_enable_pattern();
        logic a;
        for (int i = 0; i < 16; i++) wbuf[i] = 8'(8'h3B * i + 8'h81);
        model_en();
        wr_regs(DEV, 8'h00, 16, a);
        rd_regs(8'h00, 16);
        for (int i = 0; i < 16; i++) chk("R3 R10 enable readback", 128'(rbuf[i]), 128'(wbuf[i]));
        pulse_and_check("R4 R8 mixed pattern", exp_en);
        @(negedge clk); cmd_strobe = 1'b1;
        @(negedge clk);
        chk("R8 back-to-back first", chan_fire, exp_en);
        @(negedge clk); cmd_strobe = 1'b0;
        chk("R8 back-to-back second", chan_fire, exp_en);
        @(negedge clk);
        chk("R8 back-to-back end", chan_fire, '0);
    endtask

    task automatic t_dac();
        logic a;
        wbuf[0] = 8'hAB; wbuf[1] = 8'hCD;
        wr_regs(DEV, 8'h10, 2, a);
        chk("R5 dac code", 128'(dac_code), 128'(16'hABCD));
        rd_regs(8'h10, 2);
        chk("R5 R10 dac hi readback", 128'(rbuf[0]), 128'(8'hAB));
        chk("R5 R10 dac lo readback", 128'(rbuf[1]), 128'(8'hCD));
    endtask

    task automatic t_delay();
        logic a;
        logic [7:0] inv [0:7];
        logic [4:0] ex [0:7];
        logic [39:0] exf;
        inv[0] = 8'd0;  inv[1] = 8'd1;  inv[2] = 8'd24; inv[3] = 8'd25;
        inv[4] = 8'd31; inv[5] = 8'd255; inv[6] = 8'd12; inv[7] = 8'd23;
        for (int i = 0; i < 8; i++) begin
            wbuf[i] = inv[i];
            ex[i] = (inv[i] > 8'd24) ? 5'd24 : inv[i][4:0];
            exf[5*i +: 5] = ex[i];
        end
        wr_regs(DEV, 8'h12, 8, a);
        chk("R6 delay outputs clamped", 128'(bulk_delay), 128'(exf));
        rd_regs(8'h12, 8);
        for (int i = 0; i < 8; i++) chk("R6 R10 delay readback", 128'(rbuf[i]), 128'(ex[i]));
    endtask

    task automatic t_ctl_temp();
        logic a;
        wbuf[0] = 8'hF5;
        wr_regs(DEV, 8'h1A, 1, a);
        chk("R7 regulator bits", 128'(reg_ctl), 128'(4'h5));
        wbuf[0] = 8'h03; wbuf[1] = 8'h00;
        wr_regs(DEV, 8'h1A, 2, a);
        chk("R3 R7 ctl via increment", 128'(reg_ctl), 128'(4'h3));
        rd_regs(8'h1A, 2);
        chk("R7 ctl readback", 128'(rbuf[0]), 128'(8'h03));
        chk("R7 temp unaffected by write", 128'(rbuf[1]), 128'(8'h5A));
        temp_code = 8'hC3;
        rd_regs(8'h1B, 1);
        chk("R7 temp follows input", 128'(rbuf[0]), 128'(8'hC3));
    endtask

    task automatic t_bad_addr();
        logic a;
        wbuf[0] = 8'h11;
        wr_regs(7'h2D, 8'h10, 1, a);
        chk("R2 no ack foreign address", 128'(a), '0);
        chk("R2 foreign write ignored", 128'(dac_code), 128'(16'hABCD));
        wbuf[0] = 8'h55;
        wr_regs(DEV, 8'h30, 1, a);
        rd_regs(8'h30, 1);
        chk("R10 unmapped reads zero", 128'(rbuf[0]), '0);
    endtask

    task automatic t_defer();
        logic a;
        i2c_start();
        i2c_wbyte({DEV, 1'b0}, a);
        i2c_wbyte(8'h10, a);
        @(negedge clk); cmd_strobe = 1'b1;
        i2c_wbyte(8'h3C, a);
        repeat (10) @(negedge clk);
        chk("R9 write held during strobe", 128'(dac_code), 128'(16'hABCD));
        chk("R9 R8 old enables fire", chan_fire, exp_en);
        cmd_strobe = 1'b0;
        repeat (3) @(negedge clk);
        chk("R9 write applied after strobe", 128'(dac_code), 128'(16'h3CCD));
        i2c_stop();
        hp();
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_single_channel();
        t_enable_pattern();
        t_dac();
        t_delay();
        t_ctl_temp();
        t_bad_addr();
        t_defer();
        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule